// File: doc/BRIEF.md
# Sigma-Delta CIC Decimator with Limit Trip

This block turns a one-bit sigma-delta modulator stream into multi-bit samples. Each input bit arrives with a one-cycle strobe, `bit_en`. The bits pass through a cascaded integrator-comb filter. The filter is third order when `order3` is high and second order when it is low. The decimation ratio `osr` is programmable. A free-running count of input bits is exposed as `samp_cnt`. A decimation event happens only when this count reaches the previous capture point plus `osr`, so no external timing source can change the spacing between outputs.

Two consumers share the same integrators, combs and counter:

- **Limit-checking path.** It runs continuously. It compares every settled output with an upper and a lower limit, and sets a sticky error flag on a violation.
- **Sampling path.** It is armed by `nc_start`. It waits for the filter to flush and then returns one settled sample.

A synchronous `clr` empties the integrators, the combs, the capture point, the sample counter and the error flag. It also cancels a pending sample request. Because the state is shared, a clear also blinds the limit-checking path until the filter has settled again.

**Settle-tracking machine (`fst_q`).**

- States: `FIL_FILL` and `FIL_RUN`.
- `FIL_FILL` moves to `FIL_RUN` when the output that completes the settling count is produced. That is the 3rd output after a clear or reset in third order, and the 2nd in second order.
- `clr` returns the machine to `FIL_FILL` from either state.

**Request machine (`st_q`).**

- States: `NC_IDLE` and `NC_SETTLE`.
- `NC_IDLE` moves to `NC_SETTLE` on `nc_start`.
- `NC_SETTLE` returns to `NC_IDLE` on the output that completes the settling count after the request. It also returns to `NC_IDLE` on `clr`.

Top module: `sdm_sinc_trip`

## Requirements
- R1: After reset, `samp_cnt` is 0 and `dec_vld`, `oc_err`, `nc_busy` and `nc_vld` are all low.
- R2: `samp_cnt` rises by exactly one on each `bit_en` cycle without `clr`, and otherwise holds.
- R3: Decimation is decided only by the internal count. `dec_vld` pulses for one cycle, one cycle after every `osr`-th accepted bit counted from the last output or clear. A new `osr` written right after an output sets the next spacing. `nc_start` never shifts the spacing.
- R4: In third order, a settled output equals `osr`^3 for an all-ones input and `osr`^3/2 for an alternating 1,0 input with even `osr`. An input bit of 1 counts as 1 and a 0 counts as 0.
- R5: In second order, a settled output equals `osr`^2 for all ones and `osr`^2/2 for alternating bits with even `osr`.
- R6: With all-ones input after a clear, the first output is `osr`(`osr`+1)(`osr`+2)/6 in third order and `osr`(`osr`+1)/2 in second order.
- R7: `clr` zeroes `samp_cnt`, the filter state and `oc_err`, and aborts a pending request, so `nc_busy` is low on the next cycle.
- R8: After `nc_start`, `nc_busy` is high from the next cycle. `nc_vld` pulses exactly once, one cycle after the 3rd (third order) or 2nd (second order) `dec_vld` that follows the start cycle. It carries that output on `nc_data`, and `nc_busy` is low in the same cycle.
- R9: `nc_start` while `nc_busy` is high has no effect and does not restart the settling count.
- R10: A settled output strictly above `hi_lim` or strictly below `lo_lim` sets `oc_err` on the cycle after its `dec_vld`. An output equal to a limit does not set it.
- R11: The outputs before the settling count after a clear or reset never set `oc_err`. That is the first 2 in third order and the first 1 in second order.
- R12: `oc_err` stays high until `clr`, even when later outputs are in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of filter, counter, flag and request |
| order3 | input | 1 | 1: third-order filter, 0: second-order |
| osr | input | OSR_W | Decimation ratio (2 or more) |
| hi_lim | input | ACC_W | Upper limit, unsigned |
| lo_lim | input | ACC_W | Lower limit, unsigned |
| bit_en | input | 1 | One-cycle strobe marking a valid modulator bit |
| bit_in | input | 1 | Modulator bit |
| nc_start | input | 1 | Request one settled sample |
| samp_cnt | output | CNT_W | Running count of accepted bits |
| dec_vld | output | 1 | Decimated output strobe |
| dec_data | output | ACC_W | Decimated output value |
| oc_err | output | 1 | Sticky limit violation flag |
| nc_busy | output | 1 | Sample request pending |
| nc_vld | output | 1 | Settled sample strobe |
| nc_data | output | ACC_W | Settled sample value |

## Verification
The bench goes after these corner cases:

- **Start-up output.** It checks the exact partial first output after a clear. A filter whose combs keep stale history would return a wrong value there.
- **Limit boundaries.** It places a limit exactly on the settled value. An off-by-one comparison would then trip on an in-range sample.
- **Blinding after clear.** It drives zeros after a clear. A limit path that is not blinded during settling would trip on the partial early outputs.
- **Request timing.** It sends a second `nc_start` mid-request, which would deliver a late sample if the count restarted. It also checks that `nc_start` and an `osr` change move the output spacing only as required. A design decimating from an external event would show an output gap off by one bit.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    localparam int unsigned SDM_MAX_ORDER = 3;

    typedef enum logic {
        FIL_FILL,
        FIL_RUN
    } fill_state_t;

    typedef enum logic {
        NC_IDLE,
        NC_SETTLE
    } nc_state_t;

    function automatic logic [1:0] last_stage(input logic order3);
        return order3 ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/sdm_tick.sv
module sdm_tick #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned OSR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bit_en,
    input  logic [OSR_W-1:0] osr,
    output logic [CNT_W-1:0] samp_cnt,
    output logic             dec_evt
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cap_q;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] target;

    assign cnt_nx   = cnt_q + CNT_W'(1);
    assign target   = cap_q + CNT_W'(osr);
    assign dec_evt  = bit_en && !clr && (cnt_nx == target);
    assign samp_cnt = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cap_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
            cap_q <= '0;
        end else if (bit_en) begin
            cnt_q <= cnt_nx;
            if (dec_evt) begin
                cap_q <= cnt_nx;
            end
        end
    end

endmodule

// File: rtl/sdm_integ.sv
module sdm_integ
    import sdm_pkg::*;
#(
    parameter int unsigned ACC_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic             order3,
    output logic [ACC_W-1:0] smp
);

    logic [SDM_MAX_ORDER-1:0][ACC_W-1:0] acc_q;
    logic [SDM_MAX_ORDER-1:0][ACC_W-1:0] sum_nx;

    for (genvar g = 0; g < SDM_MAX_ORDER; g++) begin : g_int
        if (g == 0) begin : g_head
            assign sum_nx[g] = acc_q[g] + ACC_W'(bit_in);
        end else begin : g_tail
            assign sum_nx[g] = acc_q[g] + sum_nx[g-1];
        end
    end

    assign smp = sum_nx[last_stage(order3)];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (bit_en) begin
            acc_q <= sum_nx;
        end
    end

endmodule

// File: rtl/sdm_comb.sv
module sdm_comb
    import sdm_pkg::*;
#(
    parameter int unsigned ACC_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             dec_evt,
    input  logic             order3,
    input  logic [ACC_W-1:0] smp,
    output logic             dec_vld,
    output logic [ACC_W-1:0] dec_data,
    output logic             dec_settled
);

    logic [SDM_MAX_ORDER-1:0][ACC_W-1:0] dly_q;
    logic [SDM_MAX_ORDER-1:0][ACC_W-1:0] din;
    logic [SDM_MAX_ORDER-1:0][ACC_W-1:0] diff;
    fill_state_t fst_q, fst_nx;
    logic [1:0]  fill_q;
    logic        fill_done;

    for (genvar g = 0; g < SDM_MAX_ORDER; g++) begin : g_cmb
        if (g == 0) begin : g_head
            assign din[g] = smp;
        end else begin : g_tail
            assign din[g] = diff[g-1];
        end
        assign diff[g] = din[g] - dly_q[g];
    end

    assign fill_done = dec_evt && (fst_q == FIL_FILL) && (fill_q == last_stage(order3));

    always_comb begin
        fst_nx = fst_q;
        unique case (fst_q)
            FIL_FILL: if (fill_done) fst_nx = FIL_RUN;
            FIL_RUN:  fst_nx = FIL_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fst_q <= FIL_FILL;
        end else if (clr) begin
            fst_q <= FIL_FILL;
        end else begin
            fst_q <= fst_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q       <= '0;
            fill_q      <= '0;
            dec_vld     <= 1'b0;
            dec_data    <= '0;
            dec_settled <= 1'b0;
        end else if (clr) begin
            dly_q       <= '0;
            fill_q      <= '0;
            dec_vld     <= 1'b0;
            dec_data    <= '0;
            dec_settled <= 1'b0;
        end else begin
            dec_vld <= dec_evt;
            if (dec_evt) begin
                dly_q       <= din;
                dec_data    <= diff[last_stage(order3)];
                dec_settled <= (fst_q == FIL_RUN) || fill_done;
                if (fst_q == FIL_FILL) begin
                    fill_q <= fill_q + 2'd1;
                end
            end
        end
    end

endmodule

// File: rtl/sdm_nc_fsm.sv
module sdm_nc_fsm
    import sdm_pkg::*;
#(
    parameter int unsigned ACC_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             nc_start,
    input  logic             order3,
    input  logic             dec_vld,
    input  logic [ACC_W-1:0] dec_data,
    output logic             nc_busy,
    output logic             nc_vld,
    output logic [ACC_W-1:0] nc_data
);

    nc_state_t st_q, st_nx;
    logic [1:0] seen_q;
    logic       last_hit;

    assign last_hit = (st_q == NC_SETTLE) && dec_vld && (seen_q == last_stage(order3));
    assign nc_busy  = (st_q == NC_SETTLE);

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            NC_IDLE:   if (nc_start) st_nx = NC_SETTLE;
            NC_SETTLE: if (last_hit) st_nx = NC_IDLE;
        endcase
        if (clr) st_nx = NC_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= NC_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q  <= '0;
            nc_vld  <= 1'b0;
            nc_data <= '0;
        end else begin
            nc_vld <= last_hit && !clr;
            if (st_q == NC_IDLE || clr) begin
                seen_q <= '0;
            end else if (dec_vld) begin
                seen_q <= seen_q + 2'd1;
            end
            if (last_hit && !clr) begin
                nc_data <= dec_data;
            end
        end
    end

endmodule

// File: rtl/sdm_sinc_trip.sv
module sdm_sinc_trip
    import sdm_pkg::*;
#(
    parameter int unsigned OSR_W = 8,
    parameter int unsigned CNT_W = 16,
    localparam int unsigned ACC_W = SDM_MAX_ORDER * OSR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             order3,
    input  logic [OSR_W-1:0] osr,
    input  logic [ACC_W-1:0] hi_lim,
    input  logic [ACC_W-1:0] lo_lim,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic             nc_start,
    output logic [CNT_W-1:0] samp_cnt,
    output logic             dec_vld,
    output logic [ACC_W-1:0] dec_data,
    output logic             oc_err,
    output logic             nc_busy,
    output logic             nc_vld,
    output logic [ACC_W-1:0] nc_data
);

    logic             dec_evt;
    logic             dec_settled;
    logic [ACC_W-1:0] smp;

    sdm_tick #(.CNT_W(CNT_W), .OSR_W(OSR_W)) i_tick (
        .clk(clk), .rst_n(rst_n), .clr(clr), .bit_en(bit_en), .osr(osr),
        .samp_cnt(samp_cnt), .dec_evt(dec_evt)
    );

    sdm_integ #(.ACC_W(ACC_W)) i_integ (
        .clk(clk), .rst_n(rst_n), .clr(clr), .bit_en(bit_en), .bit_in(bit_in),
        .order3(order3), .smp(smp)
    );

    sdm_comb #(.ACC_W(ACC_W)) i_comb (
        .clk(clk), .rst_n(rst_n), .clr(clr), .dec_evt(dec_evt), .order3(order3),
        .smp(smp), .dec_vld(dec_vld), .dec_data(dec_data), .dec_settled(dec_settled)
    );

    sdm_nc_fsm #(.ACC_W(ACC_W)) i_nc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .nc_start(nc_start), .order3(order3),
        .dec_vld(dec_vld), .dec_data(dec_data), .nc_busy(nc_busy), .nc_vld(nc_vld),
        .nc_data(nc_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oc_err <= 1'b0;
        end else if (clr) begin
            oc_err <= 1'b0;
        end else if (dec_vld && dec_settled && (dec_data > hi_lim || dec_data < lo_lim)) begin
            oc_err <= 1'b1;
        end
    end

endmodule

// File: rtl/sdm_sinc_trip_chk.sv
module sdm_sinc_trip_chk #(
    parameter int unsigned ACC_W = 25,
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             bit_en,
    input logic [CNT_W-1:0] samp_cnt,
    input logic             dec_vld,
    input logic [ACC_W-1:0] dec_data,
    input logic             oc_err,
    input logic             nc_busy,
    input logic             nc_vld,
    input logic [ACC_W-1:0] nc_data
);

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !clr) |=> samp_cnt == $past(samp_cnt) + CNT_W'(1));

    a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !clr) |=> $stable(samp_cnt));

    a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (samp_cnt == '0 && !oc_err && !nc_busy && !dec_vld));

    a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_err && !clr) |=> oc_err);

    a_r10_trip_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oc_err) |-> $past(dec_vld));

    a_r8_nc_source: assert property (@(posedge clk) disable iff (!rst_n)
        nc_vld |-> ($past(dec_vld) && nc_data == $past(dec_data) && !nc_busy));

    a_r8_nc_single: assert property (@(posedge clk) disable iff (!rst_n)
        nc_vld |=> !nc_vld);

endmodule

bind sdm_sinc_trip sdm_sinc_trip_chk #(.ACC_W(ACC_W), .CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_en(bit_en), .samp_cnt(samp_cnt),
    .dec_vld(dec_vld), .dec_data(dec_data), .oc_err(oc_err), .nc_busy(nc_busy),
    .nc_vld(nc_vld), .nc_data(nc_data)
);

// File: tb/test_sdm_sinc_trip.sv
module test_sdm_sinc_trip;

    localparam int OSR_W = 8;
    localparam int CNT_W = 16;
    localparam int ACC_W = 3 * OSR_W + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr = 1'b0;
    logic             order3 = 1'b1;
    logic [OSR_W-1:0] osr = 8'd32;
    logic [ACC_W-1:0] hi_lim = '1;
    logic [ACC_W-1:0] lo_lim = '0;
    logic             bit_en = 1'b0;
    logic             bit_in = 1'b0;
    logic             nc_start = 1'b0;
    logic [CNT_W-1:0] samp_cnt;
    logic             dec_vld;
    logic [ACC_W-1:0] dec_data;
    logic             oc_err;
    logic             nc_busy;
    logic             nc_vld;
    logic [ACC_W-1:0] nc_data;

    int checks = 0;
    int errors = 0;
    int bits_sent = 0;
    int last_mark = 0;
    int exp_gap = 32;
    int gap_err = 0;
    int out_n = 0;
    longint last_out = 0;
    int nc_n = 0;
    int nc_at_out = 0;
    longint nc_last = 0;

    always #4 clk = ~clk;

    sdm_sinc_trip #(.OSR_W(OSR_W), .CNT_W(CNT_W)) i_sdm_sinc_trip (
        .clk(clk), .rst_n(rst_n), .clr(clr), .order3(order3), .osr(osr),
        .hi_lim(hi_lim), .lo_lim(lo_lim), .bit_en(bit_en), .bit_in(bit_in),
        .nc_start(nc_start), .samp_cnt(samp_cnt), .dec_vld(dec_vld),
        .dec_data(dec_data), .oc_err(oc_err), .nc_busy(nc_busy), .nc_vld(nc_vld),
        .nc_data(nc_data)
    );

    always @(negedge clk) begin
        if (dec_vld) begin
            if (bits_sent - last_mark != exp_gap) gap_err++;
            last_mark = bits_sent;
            out_n++;
            last_out = dec_data;
        end
        if (nc_vld) begin
            nc_n++;
            nc_at_out = out_n;
            nc_last = nc_data;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // kind: 0 zeros, 1 ones, 2 alternating
    task automatic send_bits(input int n, input int kind);
        for (int i = 0; i < n; i++) begin
            bit_in = (kind == 1) ? 1'b1 : (kind == 2) ? bits_sent[0] : 1'b0;
            bit_en = 1'b1;
            bits_sent++;
            @(negedge clk);
            bit_en = 1'b0;
            @(negedge clk);
        end
        #1;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        last_mark = bits_sent;
        #1;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        nc_start = 1'b1;
        @(negedge clk);
        nc_start = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        chk("R1 samp_cnt", samp_cnt, 0);
        chk("R1 dec_vld", dec_vld, 0);
        chk("R1 oc_err", oc_err, 0);
        chk("R1 nc_busy", nc_busy, 0);
        chk("R1 nc_vld", nc_vld, 0);
    endtask

    task automatic t_order3();
        int n0;
        order3 = 1'b1; osr = 8'd32; exp_gap = 32; hi_lim = '1; lo_lim = '0;
        pulse_clr();
        chk("R7 samp_cnt after clr", samp_cnt, 0);
        n0 = out_n;
        send_bits(32, 1);
        chk("R3 one output per osr bits", out_n - n0, 1);
        chk("R6 first output order3", last_out, 32 * 33 * 34 / 6);
        send_bits(64, 1);
        chk("R4 settled ones order3", last_out, 32768);
        chk("R2 samp_cnt counts bits", samp_cnt, 96);
        send_bits(96, 2);
        chk("R4 settled alternating order3", last_out, 16384);
        chk("R3 gap errors", gap_err, 0);
    endtask

    task automatic t_order2();
        order3 = 1'b0; osr = 8'd64; exp_gap = 64;
        pulse_clr();
        send_bits(64, 1);
        chk("R6 first output order2", last_out, 64 * 65 / 2);
        send_bits(64, 1);
        chk("R5 settled ones order2", last_out, 4096);
        send_bits(128, 2);
        chk("R5 settled alternating order2", last_out, 2048);
        chk("R3 gap errors order2", gap_err, 0);
    endtask

    task automatic t_osr_change();
        int n0;
        order3 = 1'b1; osr = 8'd32; exp_gap = 32;
        pulse_clr();
        send_bits(32, 1);
        osr = 8'd48; exp_gap = 48;
        n0 = out_n;
        send_bits(96, 1);
        chk("R3 outputs after osr change", out_n - n0, 2);
        chk("R3 gap after osr change", gap_err, 0);
        osr = 8'd32; exp_gap = 32;
    endtask

    task automatic t_nc3();
        int n0;
        int k0;
        order3 = 1'b1; osr = 8'd32; exp_gap = 32;
        pulse_clr();
        send_bits(96, 1);
        send_bits(10, 1);
        n0 = out_n; k0 = nc_n;
        pulse_start();
        chk("R8 busy after start", nc_busy, 1);
        send_bits(30, 1);
        pulse_start();
        send_bits(66, 1);
        chk("R8 single settled sample", nc_n - k0, 1);
        chk("R9 sample on third output after first start", nc_at_out - n0, 3);
        chk("R8 settled sample value", nc_last, 32768);
        chk("R8 busy cleared", nc_busy, 0);
        send_bits(64, 1);
        chk("R8 no further samples", nc_n - k0, 1);
        chk("R3 nc_start leaves spacing", gap_err, 0);
    endtask

    task automatic t_nc2();
        int n0;
        int k0;
        order3 = 1'b0; osr = 8'd32; exp_gap = 32;
        pulse_clr();
        send_bits(96, 1);
        send_bits(5, 1);
        n0 = out_n; k0 = nc_n;
        pulse_start();
        send_bits(64, 1);
        chk("R8 order2 single sample", nc_n - k0, 1);
        chk("R8 order2 on second output", nc_at_out - n0, 2);
        chk("R8 order2 value", nc_last, 1024);
        order3 = 1'b1;
        pulse_clr();
    endtask

    task automatic t_limits();
        order3 = 1'b1; osr = 8'd32; exp_gap = 32;
        lo_lim = 25'd10000; hi_lim = 25'd40000;
        pulse_clr();
        send_bits(32, 1);
        chk("R11 early low output ignored", oc_err, 0);
        send_bits(64, 1);
        chk("R10 in-range output no trip", oc_err, 0);
        hi_lim = 25'd32768;
        send_bits(32, 1);
        chk("R10 equal to high limit no trip", oc_err, 0);
        hi_lim = 25'd32767;
        send_bits(32, 1);
        chk("R10 above high limit trips", oc_err, 1);
        hi_lim = 25'd40000;
        send_bits(64, 1);
        chk("R12 flag stays set", oc_err, 1);
        pulse_clr();
        chk("R7 clr drops flag", oc_err, 0);
        send_bits(64, 0);
        chk("R11 unsettled zero outputs ignored", oc_err, 0);
        send_bits(32, 0);
        chk("R10 below low limit trips", oc_err, 1);
        hi_lim = '1; lo_lim = '0;
        pulse_clr();
    endtask

    task automatic t_clear_mid();
        int k0;
        order3 = 1'b1; osr = 8'd32; exp_gap = 32;
        pulse_clr();
        send_bits(96, 1);
        k0 = nc_n;
        pulse_start();
        send_bits(10, 1);
        pulse_clr();
        chk("R7 samp_cnt zero", samp_cnt, 0);
        chk("R7 request aborted", nc_busy, 0);
        send_bits(32, 1);
        chk("R7 filter emptied", last_out, 32 * 33 * 34 / 6);
        send_bits(96, 1);
        chk("R7 aborted request yields nothing", nc_n - k0, 0);
        chk("R3 spacing restarts at clear", gap_err, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_order3();
        t_order2();
        t_osr_change();
        t_nc3();
        t_nc2();
        t_limits();
        t_clear_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule